// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarms

This block is a memory-mapped real-time clock core. It advances on a one-pulse-per-second tick enable. It keeps two 32-bit seconds counters that step together: one counts up and one counts down. Two 32-bit compare registers are checked against the up-counter. Each hit latches a status flag, which software clears by writing a one to it.

The status flags drive two outputs. The alarm interrupt line follows the flags that have their interrupt enable set. The wake output follows the flags that have a separate wake enable set, and a control bit can also hold it high.

A control register can stop both counters so software can load a new time. It also provides a level soft reset. A general-purpose key register lets firmware record that the clock has already been configured. The bus is a simple single-cycle port: writes land at the clock edge and reads are combinational.

Top module: `sec_rtc`

## Requirements
- R1: After hardware reset both counters, control, status and key read 0, both compare registers read 0xFFFFFFFF, and both outputs are low.
- R2: On each cycle with tick_i high and control bit 6 clear, the up-counter adds 1 and the down-counter subtracts 1, each wrapping modulo 2^32.
- R3: While control bit 6 is set, ticks leave both counters unchanged. A write to byte offset 0x00 loads the up-counter and a write to 0x04 loads the down-counter; each load is independent of the other and takes priority over a tick.
- R4: Status bit 0 (compare 0 at offset 0x08) or bit 1 (compare 1 at offset 0x0C) is set one cycle after the up-counter equals that compare register. The bit is set again on every cycle for as long as the two stay equal.
- R5: Writing to the status register at 0x14 clears each bit written as 1 and leaves each bit written as 0 unchanged. A set condition in the same cycle wins over the clear.
- R6: alarm_irq_o is high exactly when (status bit 0 and control bit 0) or (status bit 1 and control bit 1) hold.
- R7: wake_o is high when control bit 7 is set, or when status bit 0 and control bit 2 are set, or when status bit 1 and control bit 3 are set. Status bit 2 is set one cycle after wake_o is high.
- R8: While control bit 4 is set, both counters and all status bits are cleared one cycle later and stay cleared; key and compare registers keep their values.
- R9: The key register at 0x18 is a 32-bit read/write register; for example it stores 0xB5C13F27 and reads it back unchanged.
- R10: Reads return the register at its word offset (control at 0x10 on bits 7:0, bit 5 always 0). Unmapped offsets (0x1C) and addresses with nonzero bits 1:0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second advance enable |
| addr_i | input | 5 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| alarm_irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Wake output |

## Verification
A write or a tick is visible on rdata_o in the cycle after its clock edge. A status flag appears one edge after the counter reaches its compare value. alarm_irq_o and wake_o follow the flags in that same cycle, and status bit 2 trails wake_o by one more edge. The driver changes inputs on the falling edge and queues each expectation at the cycle where that latency puts it. The monitor samples a quarter period later, before the next rising edge, so the zero-then-one step of every flag is checked cycle by cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned NUM_CMP  = 2;
  localparam int unsigned STAT_W   = NUM_CMP + 1;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [2:0] {
    REG_UP    = 3'd0,
    REG_DOWN  = 3'd1,
    REG_CMP0  = 3'd2,
    REG_CMP1  = 3'd3,
    REG_CTRL  = 3'd4,
    REG_STAT  = 3'd5,
    REG_KEY   = 3'd6,
    REG_NONE  = 3'd7
  } reg_idx_e;

  localparam int unsigned CB_IRQ0  = 0;
  localparam int unsigned CB_IRQ1  = 1;
  localparam int unsigned CB_WAKE0 = 2;
  localparam int unsigned CB_WAKE1 = 3;
  localparam int unsigned CB_SRST  = 4;
  localparam int unsigned CB_HOLD  = 6;
  localparam int unsigned CB_FORCE = 7;

  localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'hDF;
endpackage

// File: rtl/rtc_counter_pair.sv
module rtc_counter_pair #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic         tick_i,
  input  logic         ld_up_i,
  input  logic         ld_dn_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] up_o,
  output logic [W-1:0] dn_o
);
  logic step;
  assign step = tick_i && !hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_o <= '0;
      dn_o <= '0;
    end else if (clr_i) begin
      up_o <= '0;
      dn_o <= '0;
    end else begin
      if (ld_up_i)   up_o <= wdata_i;
      else if (step) up_o <= up_o + W'(1);
      if (ld_dn_i)   dn_o <= wdata_i;
      else if (step) dn_o <= dn_o - W'(1);
    end
  end
endmodule

// File: rtl/rtc_cmp_chan.sv
module rtc_cmp_chan #(
  parameter int unsigned   W       = 32,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] cmp_o,
  output logic         hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_o <= RST_VAL;
    else if (ld_i) cmp_o <= wdata_i;
  end

  assign hit_o = (cnt_i == cmp_o);
endmodule

// File: rtl/rtc_status.sv
module rtc_status #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] hit_i,
  input  logic         w1c_i,
  input  logic [N:0]   wdata_i,
  input  logic [N-1:0] irq_en_i,
  input  logic [N-1:0] wake_en_i,
  input  logic         force_i,
  output logic [N:0]   status_o,
  output logic         irq_o,
  output logic         wake_o
);
  logic [N:0] set_v, clr_v;

  assign irq_o  = |(status_o[N-1:0] & irq_en_i);
  assign wake_o = force_i || (|(status_o[N-1:0] & wake_en_i));
  assign set_v  = {wake_o, hit_i};
  assign clr_v  = w1c_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     status_o <= '0;
    else if (clr_i)  status_o <= '0;
    else             status_o <= set_v | (status_o & ~clr_v);
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import rtc_pkg::*;
#(
  parameter logic [DATA_W-1:0] CMP_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              alarm_irq_o,
  output logic              wake_o
);
  reg_idx_e          idx;
  logic              aligned;
  logic [7:0]        wsel;
  logic [CTRL_W-1:0] ctrl_q;
  word_t             key_q;
  word_t             up_cnt, dn_cnt;
  word_t             cmp_q [NUM_CMP];
  logic [NUM_CMP-1:0] hit;
  logic [STAT_W-1:0] status;
  logic [NUM_CMP-1:0] irq_en, wake_en;

  assign idx     = reg_idx_e'(addr_i[ADDR_W-1:2]);
  assign aligned = (addr_i[1:0] == 2'b00);

  // one write strobe per word slot
  always_comb begin
    wsel = '0;
    if (we_i && aligned) wsel[idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      key_q  <= '0;
    end else begin
      if (wsel[REG_CTRL]) ctrl_q <= wdata_i[CTRL_W-1:0] & CTRL_WMASK;
      if (wsel[REG_KEY])  key_q  <= wdata_i;
    end
  end

  rtc_counter_pair #(.W(DATA_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (ctrl_q[CB_SRST]),
    .hold_i  (ctrl_q[CB_HOLD]),
    .tick_i  (tick_i),
    .ld_up_i (wsel[REG_UP]),
    .ld_dn_i (wsel[REG_DOWN]),
    .wdata_i (wdata_i),
    .up_o    (up_cnt),
    .dn_o    (dn_cnt)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    rtc_cmp_chan #(.W(DATA_W), .RST_VAL(CMP_RST)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_i    (wsel[int'(REG_CMP0) + k]),
      .wdata_i (wdata_i),
      .cnt_i   (up_cnt),
      .cmp_o   (cmp_q[k]),
      .hit_o   (hit[k])
    );
    assign irq_en[k]  = ctrl_q[CB_IRQ0 + k];
    assign wake_en[k] = ctrl_q[CB_WAKE0 + k];
  end

  rtc_status #(.N(NUM_CMP)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (ctrl_q[CB_SRST]),
    .hit_i     (hit),
    .w1c_i     (wsel[REG_STAT]),
    .wdata_i   (wdata_i[STAT_W-1:0]),
    .irq_en_i  (irq_en),
    .wake_en_i (wake_en),
    .force_i   (ctrl_q[CB_FORCE]),
    .status_o  (status),
    .irq_o     (alarm_irq_o),
    .wake_o    (wake_o)
  );

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (idx)
        REG_UP:   rdata_o = up_cnt;
        REG_DOWN: rdata_o = dn_cnt;
        REG_CMP0: rdata_o = cmp_q[0];
        REG_CMP1: rdata_o = cmp_q[1];
        REG_CTRL: rdata_o = DATA_W'(ctrl_q);
        REG_STAT: rdata_o = DATA_W'(status);
        REG_KEY:  rdata_o = key_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_rtc_sva.sv
module sec_rtc_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick_i,
  input logic [4:0]  addr_i,
  input logic        we_i,
  input logic [31:0] wdata_i,
  input logic        alarm_irq_o,
  input logic        wake_o,
  input logic [7:0]  ctrl,
  input logic [2:0]  stat,
  input logic [31:0] up,
  input logic [31:0] dn,
  input logic [31:0] cmp0,
  input logic [31:0] key
);
  logic wr_up, wr_dn, wr_stat, wr_key;
  assign wr_up   = we_i && addr_i == 5'h00;
  assign wr_dn   = we_i && addr_i == 5'h04;
  assign wr_stat = we_i && addr_i == 5'h14;
  assign wr_key  = we_i && addr_i == 5'h18;

  AST_TICK_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ctrl[6] && !ctrl[4] && !wr_up) |=> up == $past(up) + 32'd1); // R2
  AST_TICK_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ctrl[6] && !ctrl[4] && !wr_dn) |=> dn == $past(dn) - 32'd1); // R2
  AST_HOLD_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[6] && !ctrl[4] && !wr_up) |=> $stable(up)); // R3
  AST_CMP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[4] && up == cmp0) |=> stat[0]); // R4
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[0] && !ctrl[4] && !(wr_stat && wdata_i[0])) |=> stat[0]); // R5
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> (stat[1:0] != 2'b00)); // R6
  AST_FORCE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[7] |-> wake_o); // R7
  AST_SOFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[4] |=> (up == 32'd0 && dn == 32'd0 && stat == 3'd0)); // R8
  AST_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_key |=> $stable(key)); // R9
endmodule

bind sec_rtc sec_rtc_sva u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .alarm_irq_o (alarm_irq_o),
  .wake_o      (wake_o),
  .ctrl        (ctrl_q),
  .stat        (status),
  .up          (up_cnt),
  .dn          (dn_cnt),
  .cmp0        (cmp_q[0]),
  .key         (key_q)
);

// File: tb/sec_rtc_tb_top.sv
module sec_rtc_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        alarm_irq_o, wake_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 wake
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  sec_rtc dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .alarm_irq_o(alarm_irq_o), .wake_o(wake_o)
  );

  // monitor: samples a quarter period after the falling edge
  initial forever begin
    @(negedge clk);
    #5;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = rdata_o;
        1:       act = {31'b0, alarm_irq_o};
        default: act = {31'b0, wake_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    we_i = 1'b0;
  endtask

  task automatic tk();
    tick_i = 1'b1;
    step();
    tick_i = 1'b0;
  endtask

  task automatic pin(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    addr_i = a;
    pin(0, e, tag);
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    // R1 reset state, R10 map
    pin(1, 0, "R1 irq"); pin(2, 0, "R1 wake");
    rd(5'h00, 32'h0, "R1 up");
    rd(5'h04, 32'h0, "R1 down");
    rd(5'h08, 32'hFFFFFFFF, "R1 cmp0");
    rd(5'h0C, 32'hFFFFFFFF, "R1 cmp1");
    rd(5'h10, 32'h0, "R1 ctrl");
    rd(5'h14, 32'h0, "R1 status");
    rd(5'h18, 32'h0, "R1 key");
    // R9 key
    wr(5'h18, 32'hB5C13F27);
    rd(5'h18, 32'hB5C13F27, "R9 key");
    rd(5'h1C, 32'h0, "R10 unmapped");
    rd(5'h19, 32'h0, "R10 misaligned");
    // R2 counting and down wrap
    tk(); tk(); tk();
    rd(5'h00, 32'd3, "R2 up");
    rd(5'h04, 32'hFFFFFFFD, "R2 down wrap");
    // R3 freeze and load
    wr(5'h10, 32'h40);
    rd(5'h10, 32'h40, "R10 ctrl");
    tk(); tk();
    rd(5'h00, 32'd3, "R3 hold");
    wr(5'h00, 32'd100);
    wr(5'h04, 32'hFFFFFF9B);
    tk();
    rd(5'h00, 32'd100, "R3 load up");
    rd(5'h04, 32'hFFFFFF9B, "R3 load down");
    // R4 compare 0 with interrupt
    wr(5'h08, 32'd102);
    wr(5'h10, 32'h01);
    tk();
    rd(5'h14, 32'h0, "R4 no match yet");
    tk();
    pin(1, 0, "R6 irq before flag");
    rd(5'h14, 32'h0, "R4 latency");
    pin(1, 1, "R6 irq");
    rd(5'h14, 32'h1, "R4 flag set");
    wr(5'h14, 32'h1);
    rd(5'h14, 32'h1, "R5 set wins over clear");
    wr(5'h08, 32'hFFFFFFFF);
    wr(5'h14, 32'h0);
    rd(5'h14, 32'h1, "R5 zero write no effect");
    wr(5'h14, 32'h1);
    pin(1, 0, "R6 irq cleared");
    rd(5'h14, 32'h0, "R5 clear");
    // R7 compare 1 routed to wake only
    wr(5'h10, 32'h08);
    wr(5'h0C, 32'd103);
    tk();
    rd(5'h14, 32'h0, "R4 cmp1 latency");
    pin(2, 1, "R7 wake from cmp1");
    pin(1, 0, "R6 irq gated");
    rd(5'h14, 32'h2, "R4 cmp1 flag");
    rd(5'h14, 32'h6, "R7 wake event flag");
    wr(5'h0C, 32'hFFFFFFFF);
    wr(5'h14, 32'h7);
    pin(2, 0, "R7 wake drops");
    rd(5'h14, 32'h4, "R5 wake event re-set wins");
    wr(5'h14, 32'h4);
    rd(5'h14, 32'h0, "R5 wake flag clear");
    // R7 force
    wr(5'h10, 32'h80);
    pin(2, 1, "R7 force");
    rd(5'h10, 32'h80, "R10 ctrl force bit");
    rd(5'h14, 32'h4, "R7 forced event flag");
    wr(5'h10, 32'h0);
    wr(5'h14, 32'h4);
    pin(2, 0, "R7 force off");
    rd(5'h14, 32'h0, "R5 clear after force");
    // R2 up wrap
    wr(5'h08, 32'd5);
    wr(5'h0C, 32'd5);
    wr(5'h10, 32'h40);
    wr(5'h00, 32'hFFFFFFFF);
    wr(5'h04, 32'h0);
    wr(5'h10, 32'h0);
    tk();
    rd(5'h00, 32'h0, "R2 up wrap");
    rd(5'h04, 32'hFFFFFFFF, "R2 down wrap2");
    // R8 soft reset
    wr(5'h10, 32'h80);
    tk();
    rd(5'h14, 32'h4, "R8 pre flag");
    wr(5'h10, 32'h10);
    step();
    rd(5'h00, 32'h0, "R8 up cleared");
    rd(5'h04, 32'h0, "R8 down cleared");
    tk();
    rd(5'h00, 32'h0, "R8 held");
    rd(5'h14, 32'h0, "R8 status cleared");
    rd(5'h18, 32'hB5C13F27, "R8 key kept");
    rd(5'h08, 32'd5, "R8 cmp kept");
    wr(5'h10, 32'h0);
    rd(5'h10, 32'h0, "R10 ctrl off");
    step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule